// File: doc/BRIEF.md
# Primed Result Readout Controller

This block holds one block of N transform results and lets a host drain them through a strobed output port. A result buffer is filled through a simple write port. A completion pulse marks a finished block, and the block then raises a data-available flag. The host reads with a strobe that counts only while a read enable is high. Each counted strobe advances an address generator and pushes one entry through a four-stage priming pipeline that sits between the buffer and the output. Because of this pipeline, the first four counted strobes after data-available rises only prime the path. Bin 0 reaches the output on the fourth, and the host captures it on the fifth.

A mode-definition input clears the counters. After it is released, and also after reset, four strobes must occur before the block will accept a new block. These strobes count whether or not the read enable is high. A hold-mode control selects how data-available ends. Normally it drops on the strobe after the last bin has been shown. In hold mode it stays high until the next rising edge of the input-enable signal.

With N = 1024, the block refuses buffer writes while results are still unread. With N = 256, writes are always accepted, so a slow host can see results that newer data has already overwritten.

Top module: `result_drain`

## Requirements
- R1: After reset, dataAvail, outValid, initErr and outData are all 0.
- R2: After reset, or after modeDef falls, four rdStrobe pulses are needed before the block is initialised; rdEn does not matter for these pulses. A blockDone pulse that arrives before initialisation leaves dataAvail low.
- R3: An rdStrobe with rdEn high while the block is not initialised sets initErr. initErr then stays set until reset and is not cleared by modeDef.
- R4: When the block is initialised and dataAvail is low, dataAvail rises one cycle after a blockDone pulse. A blockDone pulse while dataAvail is high has no effect on the read sequence.
- R5: Only an rdStrobe with rdEn high while dataAvail is high advances the read sequence.
- R6: After dataAvail rises, the 4th counted strobe presents bin 0. Each later counted strobe presents the next bin, and outIndex carries the bin number.
- R7: outValid is high only while rdEn is high and a bin is presented. While outValid is low, outData and outIndex are 0.
- R8: With holdMode low, dataAvail falls on the counted strobe that follows the one that presented bin N-1. That is counted strobe number N+4.
- R9: With holdMode high, dataAvail stays high after the last bin. It falls one cycle after inEn is first sampled high following a low sample, provided bin N-1 has already been presented.
- R10: With N = 1024, loadAllow is low while dataAvail is high and buffer writes are then ignored. With N = 256, loadAllow is always high and a write overwrites a bin even if that bin has not been read.
- R11: modeDef high clears dataAvail and the presented bin, and the block must be initialised again before it can re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeDef | input | 1 | Mode definition; while high, counters are held cleared |
| holdMode | input | 1 | 1: data-available ends on an input-enable rising edge |
| inEn | input | 1 | Input enable level, edge detected inside the block |
| blockDone | input | 1 | Pulse marking a completed result block |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | $clog2(N) | Buffer write address |
| wrData | input | DW | Buffer write data |
| rdStrobe | input | 1 | Host read strobe, one-cycle pulse per strobe edge |
| rdEn | input | 1 | Host read enable |
| dataAvail | output | 1 | A block is ready or being read |
| loadAllow | output | 1 | New input data may be written |
| initErr | output | 1 | Sticky flag for an enabled read before initialisation |
| outValid | output | 1 | Output drive qualifier |
| outData | output | DW | Presented result |
| outIndex | output | $clog2(N) | Bin number of the presented result |

## Verification
If the address counter is wrong, bins come out shifted or repeated. This shows on outIndex on the very next counted strobe, or, if only the end count is wrong, as a dataAvail fall that is one strobe too early or too late. A wrong priming depth moves the first outValid away from the fourth counted strobe. If the initialisation counter is wrong, a blockDone pulse arms the block one cycle too early, or initErr rises for a read that was legal. A missing write guard in the large configuration shows up only when the guarded bin is read later, so the bench captures that bin and compares its data when it appears.

// File: rtl/drain_pkg.sv
package drain_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic clear;  // reset or mode change: flush pipeline
    logic arm;    // new block accepted: flush pipeline
    logic shift;  // counted read: fetch and advance
    logic live;   // fetched address lies inside the block
  } drainCmd_t;
endpackage

// File: rtl/drain_ctrl.sv
module drain_ctrl
  import drain_pkg::*;
#(
  parameter int N = 256,
  parameter int PRIME = 4,
  parameter int INIT_NEED = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeDef,
  input  logic          holdMode,
  input  logic          inEn,
  input  logic          blockDone,
  input  logic          rdStrobe,
  input  logic          rdEn,
  output drainCmd_t     cmd,
  output logic [AW-1:0] rdAddr,
  output logic          dataAvail,
  output logic          loadAllow,
  output logic          initErr
);
  localparam int DONE = N + PRIME;
  localparam int CW = $clog2(DONE + 1);
  localparam int IW = $clog2(INIT_NEED + 1);
  localparam bit BIG = (N >= 1024);

  logic [CW-1:0] cnt;
  logic [IW-1:0] initCnt;
  logic inEnQ, initDone, inEdge, lastSeen, arm, shift;

  assign initDone = (initCnt == IW'(INIT_NEED));
  assign inEdge   = inEn && !inEnQ;
  assign lastSeen = (cnt >= CW'(DONE - 1));
  assign arm      = blockDone && initDone && !dataAvail;
  assign shift    = dataAvail && rdStrobe && rdEn && (cnt < CW'(DONE));

  assign cmd.clear = rst || modeDef;
  assign cmd.arm   = arm;
  assign cmd.shift = shift;
  assign cmd.live  = (cnt < CW'(N));
  assign rdAddr    = cnt[AW-1:0];

  generate
    if (BIG) begin : g_guarded
      assign loadAllow = !dataAvail;
    end else begin : g_open
      assign loadAllow = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    inEnQ <= inEn;
    if (rst) begin
      initErr <= 1'b0;
    end else if (!modeDef && rdStrobe && rdEn && !initDone) begin
      initErr <= 1'b1;
    end
    if (cmd.clear) begin
      initCnt   <= '0;
      dataAvail <= 1'b0;
      cnt       <= '0;
    end else begin
      if (rdStrobe && !initDone) initCnt <= initCnt + IW'(1);
      if (arm) begin
        dataAvail <= 1'b1;
        cnt       <= '0;
      end else if (shift) begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(DONE - 1) && !holdMode) dataAvail <= 1'b0;
      end else if (holdMode && inEdge && dataAvail && lastSeen) begin
        dataAvail <= 1'b0;
      end
    end
  end

  p_init_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dataAvail) |-> ($past(initCnt) == IW'(INIT_NEED)));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    initErr |=> initErr);

  p_rise_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dataAvail) |-> $past(blockDone));

  p_drop_default_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(dataAvail) && !$past(rst) && !$past(modeDef) && !$past(holdMode))
      |-> $past(rdStrobe && rdEn));

  p_drop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(dataAvail) && !$past(rst) && !$past(modeDef) && $past(holdMode))
      |-> $past(inEn));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DONE));
endmodule

// File: rtl/drain_path.sv
module drain_path
  import drain_pkg::*;
#(
  parameter int N = 256,
  parameter int DW = 16,
  parameter int PRIME = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic          wrAllow,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  drainCmd_t     cmd,
  input  logic [AW-1:0] rdAddr,
  input  logic          rdEn,
  output logic [DW-1:0] outData,
  output logic [AW-1:0] outIndex,
  output logic          outValid
);
  localparam int LAST = PRIME - 1;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] stData [PRIME];
  logic [AW-1:0] stIdx  [PRIME];
  logic          stVal  [PRIME];

  always_ff @(posedge clk) begin
    if (wrEn && wrAllow) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (cmd.clear || cmd.arm) begin
      stVal[0] <= 1'b0;
    end else if (cmd.shift) begin
      stData[0] <= mem[rdAddr];
      stIdx[0]  <= rdAddr;
      stVal[0]  <= cmd.live;
    end
  end

  generate
    for (genvar g = 1; g < PRIME; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (cmd.clear || cmd.arm) begin
          stVal[g] <= 1'b0;
        end else if (cmd.shift) begin
          stData[g] <= stData[g-1];
          stIdx[g]  <= stIdx[g-1];
          stVal[g]  <= stVal[g-1];
        end
      end
    end
  endgenerate

  assign outValid = rdEn && stVal[LAST];
  assign outData  = outValid ? stData[LAST] : '0;
  assign outIndex = outValid ? stIdx[LAST] : '0;

  p_hold_without_shift_r5: assert property (@(posedge clk) disable iff (cmd.clear)
    (!cmd.arm && !cmd.shift) |=> $stable(stIdx[LAST]) && $stable(stData[LAST]));
endmodule

// File: rtl/result_drain.sv
module result_drain
  import drain_pkg::*;
#(
  parameter int N = 256,
  parameter int DW = 16,
  parameter int PRIME = 4,
  parameter int INIT_NEED = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeDef,
  input  logic          holdMode,
  input  logic          inEn,
  input  logic          blockDone,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdStrobe,
  input  logic          rdEn,
  output logic          dataAvail,
  output logic          loadAllow,
  output logic          initErr,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic [AW-1:0] outIndex
);
  drainCmd_t     cmd;
  logic [AW-1:0] rdAddr;

  drain_ctrl #(.N(N), .PRIME(PRIME), .INIT_NEED(INIT_NEED)) u_ctrl (
    .clk(clk), .rst(rst), .modeDef(modeDef), .holdMode(holdMode),
    .inEn(inEn), .blockDone(blockDone), .rdStrobe(rdStrobe), .rdEn(rdEn),
    .cmd(cmd), .rdAddr(rdAddr), .dataAvail(dataAvail),
    .loadAllow(loadAllow), .initErr(initErr)
  );

  drain_path #(.N(N), .DW(DW), .PRIME(PRIME)) u_path (
    .clk(clk), .wrEn(wrEn), .wrAllow(loadAllow), .wrAddr(wrAddr),
    .wrData(wrData), .cmd(cmd), .rdAddr(rdAddr), .rdEn(rdEn),
    .outData(outData), .outIndex(outIndex), .outValid(outValid)
  );
endmodule

// File: tb/result_drain_test.sv
module result_drain_test;
  localparam int PERIOD = 10;

  logic clk = 0;
  logic rst = 1, modeDef = 0, holdMode = 0, inEn = 0, blockDone = 0;
  logic wrEn = 0, rdStrobe = 0, rdEn = 0;
  logic [9:0]  wrAddr = '0;
  logic [15:0] wrData = '0;

  logic sAvail, sLoad, sErr, sValid, bAvail, bLoad, bErr, bValid;
  logic [15:0] sData, bData;
  logic [7:0]  sIdx;
  logic [9:0]  bIdx;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  result_drain #(.N(256)) uut (
    .clk(clk), .rst(rst), .modeDef(modeDef), .holdMode(holdMode), .inEn(inEn),
    .blockDone(blockDone), .wrEn(wrEn), .wrAddr(wrAddr[7:0]), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdEn(rdEn), .dataAvail(sAvail), .loadAllow(sLoad),
    .initErr(sErr), .outValid(sValid), .outData(sData), .outIndex(sIdx)
  );

  result_drain #(.N(1024)) uutBig (
    .clk(clk), .rst(rst), .modeDef(modeDef), .holdMode(holdMode), .inEn(inEn),
    .blockDone(blockDone), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdEn(rdEn), .dataAvail(bAvail), .loadAllow(bLoad),
    .initErr(bErr), .outValid(bValid), .outData(bData), .outIndex(bIdx)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat(int a);
    return (a * 37 + 11) & 16'hFFFF;
  endfunction

  // ---------------- behavioural reference (index 0: N=256, 1: N=1024)
  int mMem [2][1024];
  int mInit [2], mCnt [2];
  bit mAvail [2], mErr [2], mInQ [2];
  bit pV [2][4];
  int pI [2][4], pD [2][4];
  bit cmpOn = 0;

  task automatic modelStep(int i);
    int n = (i == 0) ? 256 : 1024;
    int done = n + 4;
    bit edgeIn = inEn && !mInQ[i];
    bit wasAvail = mAvail[i];
    mInQ[i] = inEn;
    if (rst) begin
      mErr[i] = 0;
    end
    if (rst || modeDef) begin
      mInit[i] = 0; mAvail[i] = 0; mCnt[i] = 0;
      for (int k = 0; k < 4; k++) pV[i][k] = 0;
    end else begin
      bit ready = (mInit[i] == 4);
      if (rdStrobe && rdEn && !ready) mErr[i] = 1;
      if (rdStrobe && !ready) mInit[i]++;
      if (blockDone && ready && !mAvail[i]) begin
        mAvail[i] = 1; mCnt[i] = 0;
        for (int k = 0; k < 4; k++) pV[i][k] = 0;
      end else if (mAvail[i] && rdStrobe && rdEn && mCnt[i] < done) begin
        for (int k = 3; k > 0; k--) begin
          pV[i][k] = pV[i][k-1]; pI[i][k] = pI[i][k-1]; pD[i][k] = pD[i][k-1];
        end
        pV[i][0] = (mCnt[i] < n);
        pI[i][0] = mCnt[i] % n;
        pD[i][0] = mMem[i][mCnt[i] % n];
        mCnt[i]++;
        if (mCnt[i] == done && !holdMode) mAvail[i] = 0;
      end else if (holdMode && edgeIn && mAvail[i] && mCnt[i] >= done - 1) begin
        mAvail[i] = 0;
      end
    end
    if (wrEn && (i == 0 || !wasAvail)) mMem[i][wrAddr % n] = wrData;
  endtask

  always @(posedge clk) begin
    modelStep(0);
    modelStep(1);
    cmpOn = 1;
    #(PERIOD/4);
    if (!finished) begin
      check("R8 small dataAvail", sAvail, mAvail[0]);
      check("R8 large dataAvail", bAvail, mAvail[1]);
      check("R7 small outValid", sValid, rdEn && pV[0][3]);
      check("R7 large outValid", bValid, rdEn && pV[1][3]);
      check("R6 small outIndex", sIdx, (rdEn && pV[0][3]) ? pI[0][3] : 0);
      check("R6 large outIndex", bIdx, (rdEn && pV[1][3]) ? pI[1][3] : 0);
      check("R6 small outData", sData, (rdEn && pV[0][3]) ? pD[0][3] : 0);
      check("R6 large outData", bData, (rdEn && pV[1][3]) ? pD[1][3] : 0);
      check("R3 small initErr", sErr, mErr[0]);
      check("R3 large initErr", bErr, mErr[1]);
      check("R10 small loadAllow", sLoad, 1);
      check("R10 large loadAllow", bLoad, !mAvail[1]);
    end
  end

  // ---------------- stimulus helpers
  int capS200 = -1, capB200 = -1;

  task automatic strobe(bit en, int cnt);
    for (int s = 0; s < cnt; s++) begin
      rdEn = en; rdStrobe = 1;
      @(negedge clk);
      rdStrobe = 0;
      if (sValid && sIdx == 8'd200) capS200 = sData;
      if (bValid && bIdx == 10'd200) capB200 = bData;
      @(negedge clk);
    end
  endtask

  task automatic pulseDone();
    blockDone = 1;
    @(negedge clk);
    blockDone = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 dataAvail after reset", sAvail, 0);
    check("R1 outValid after reset", sValid, 0);
    check("R1 initErr after reset", sErr, 0);
    check("R1 outData after reset", sData, 0);

    pulseDone();
    check("R2 no arm before init", sAvail, 0);

    for (int a = 0; a < 1024; a++) begin
      wrEn = 1; wrAddr = 10'(a); wrData = 16'(pat(a));
      @(negedge clk);
    end
    wrEn = 0;

    strobe(0, 3);
    pulseDone();
    check("R2 three strobes not enough", bAvail, 0);
    strobe(0, 1);
    pulseDone();
    check("R4 arm after init", sAvail, 1);
    check("R3 no error from disabled strobes", sErr, 0);

    strobe(0, 5);  // R5: disabled strobes do not advance
    strobe(1, 3);
    check("R6 not primed after three", sValid, 0);
    strobe(1, 1);
    check("R6 bin0 on fourth valid", sValid, 1);
    check("R6 bin0 index", sIdx, 0);
    check("R6 small bin0 data", sData, pat(768));
    check("R5 large bin0 data", bData, pat(0));

    pulseDone();   // R4: ignored while data is available
    strobe(1, 1);
    check("R4 sequence continues", bIdx, 1);

    wrEn = 1; wrAddr = 10'd200; wrData = 16'hBEEF;
    @(negedge clk);
    wrEn = 0;

    strobe(1, 254);
    check("R8 last bin shown", sIdx, 255);
    check("R8 still available", sAvail, 1);
    strobe(1, 1);
    check("R8 drop after last", sAvail, 0);
    check("R10 large held", bAvail, 1);
    check("R10 small overwritten bin", capS200, 16'hBEEF);
    check("R10 large write ignored", capB200, pat(200));

    strobe(1, 768);
    check("R8 large drop", bAvail, 0);
    check("R10 large load allowed", bLoad, 1);

    holdMode = 1;
    pulseDone();
    strobe(1, 260);
    check("R9 holds after last", sAvail, 1);
    inEn = 1;
    @(negedge clk);
    check("R9 drop on input edge", sAvail, 0);
    check("R9 large not finished", bAvail, 1);
    inEn = 0;
    strobe(1, 768);
    check("R9 large holds", bAvail, 1);
    inEn = 1;
    @(negedge clk);
    check("R9 large drop on edge", bAvail, 0);
    inEn = 0; holdMode = 0;

    pulseDone();
    strobe(1, 6);
    modeDef = 1;
    @(negedge clk);
    check("R11 mode clears avail", sAvail, 0);
    check("R11 mode clears output", sValid, 0);
    modeDef = 0;
    @(negedge clk);
    strobe(1, 1);
    check("R3 early enabled read", sErr, 1);
    strobe(0, 3);
    pulseDone();
    check("R11 re-arm after init", sAvail, 1);
    check("R3 sticky", sErr, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R3 cleared by reset", sErr, 0);
    check("R1 avail cleared by reset", sAvail, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule